// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block keeps the control state of a single USB device OUT endpoint and decides how the endpoint answers each token the serial engine reports. The application drives one-cycle command pulses. They enable or disable the endpoint, set or clear the NAK and STALL flags, force the data toggle back to DATA0, and pick the expected frame parity for isochronous traffic. The engine side reports SETUP and OUT data tokens, with the received PID toggle, a bad-packet mark and the current frame parity, plus a transfer-complete pulse. The global IN and OUT NAK flags arrive as plain input levels.

For every token the block registers a handshake (ACK, NAK or STALL), or no handshake at all, together with an accept flag that says whether the packet is passed on. It also updates its own flags. A disable request is carried through a short fixed sequence that ends in a one-cycle endpoint-disabled interrupt. The endpoint type and the snoop setting are static configuration inputs.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset, every output is 0.
- R2: `hs_valid` and `hs_code` are registered and appear in the cycle after the token is sampled. The handshake codes are ACK=2'b00, NAK=2'b01 and STALL=2'b10. On a control, bulk or interrupt OUT token the priority is as follows. A bad packet (`tok_bad`=1 with snoop off) gets no handshake. Otherwise STALL is returned when `ep_stall` is set, even if any NAK source is active. NAK is returned when `ep_nak`, `glb_in_nak` or `glb_out_nak` is set. Otherwise ACK is returned.
- R3: Endpoint types are 00 control, 01 isochronous, 10 bulk and 11 interrupt. A SETUP token (`tok_setup`=1) on a control endpoint is always answered with ACK and accepted, whatever the STALL, NAK and enable state. It then sets `ep_nak`, clears `ep_stall` and sets the data toggle to DATA1. A SETUP token on any other type gets no handshake and changes nothing.
- R4: Set-STALL works on control, bulk and interrupt endpoints and is ignored on isochronous ones. Clear-STALL works only on bulk and interrupt endpoints and is ignored on control ones. If a set and a clear arrive in the same cycle, the set wins.
- R5: `ep_nak` is set by set-NAK, by `xfer_done` and by an accepted control SETUP, and is cleared by clear-NAK. Any set in the same cycle as a clear leaves NAK set.
- R6: On bulk, interrupt and control endpoints an ACKed OUT packet whose PID toggle (`tok_data1`) equals `ep_data1` is accepted, and the toggle flips. A mismatching PID is ACKed but not accepted, and the toggle stays. Set-DATA0 clears the toggle on bulk and interrupt endpoints only, and takes priority over a flip in the same cycle.
- R7: Set-even and set-odd change `ep_frame_odd` only on isochronous endpoints, and set-odd wins if both are given. An isochronous OUT token never gets a handshake. It is accepted only when the endpoint is enabled, no NAK source is set, the packet is good, and `tok_frame_odd` equals `ep_frame_odd`.
- R8: With `cfg_snoop`=1, a packet marked bad is treated exactly as a good one.
- R9: Disable works as a fixed sequence, counted from the edge at which `cmd_disable` is sampled while the endpoint is enabled. `ep_dis_pend` is high for exactly one cycle after that edge. `ep_enabled` and `ep_dis_pend` fall together one cycle later. `irq_ep_disabled` then pulses for one cycle. A `cmd_enable` given while the disable is pending is ignored.
- R10: A disable command given while `ep_enabled`=0 is ignored: `ep_dis_pend` stays 0 and no interrupt follows.
- R11: A control, bulk or interrupt OUT token that meets a disabled endpoint, or an endpoint with a disable pending, is answered with NAK, unless STALL applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ep_type | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_snoop | input | 1 | Pass bad packets on unchecked |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable request pulse |
| cmd_set_nak | input | 1 | Set NAK pulse |
| cmd_clr_nak | input | 1 | Clear NAK pulse |
| cmd_set_stall | input | 1 | Set STALL pulse |
| cmd_clr_stall | input | 1 | Clear STALL pulse |
| cmd_set_data0 | input | 1 | Force data toggle to DATA0 |
| cmd_set_even | input | 1 | Expect even frames (isochronous) |
| cmd_set_odd | input | 1 | Expect odd frames (isochronous) |
| glb_in_nak | input | 1 | Global IN NAK level |
| glb_out_nak | input | 1 | Global OUT NAK level |
| tok_valid | input | 1 | Token reported this cycle |
| tok_setup | input | 1 | 1 = SETUP, 0 = OUT data |
| tok_data1 | input | 1 | Received PID is DATA1 |
| tok_bad | input | 1 | Packet failed its check |
| tok_frame_odd | input | 1 | Current frame number is odd |
| xfer_done | input | 1 | Transfer-complete pulse |
| hs_valid | output | 1 | Handshake present |
| hs_code | output | 2 | Handshake code |
| rx_accept | output | 1 | Packet passed on |
| ep_enabled | output | 1 | Endpoint enabled |
| ep_dis_pend | output | 1 | Disable in progress |
| ep_nak | output | 1 | Endpoint NAK flag |
| ep_stall | output | 1 | Endpoint STALL flag |
| ep_data1 | output | 1 | Expected toggle is DATA1 |
| ep_frame_odd | output | 1 | Expected frame parity is odd |
| irq_ep_disabled | output | 1 | Endpoint-disabled interrupt pulse |

## Verification
Handshake, accept and every flag change show up one clock after the edge that samples the token or command. The disable sequence is the exception and spreads over the first, second and third cycles after the request. Stimulus is applied just after a rising edge. Every output is then compared 1 ns after the following rising edge against a cycle model in the bench, so each result is read in the cycle it is due and the disable steps are checked one cycle at a time.

// File: rtl/usb_out_ep_pkg.sv
// Shared types for the OUT endpoint controller.
// Assumes: type encoding and handshake codes are fixed by the requirements.
package usb_out_ep_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    // One-cycle application commands affecting the flag register set.
    typedef struct packed {
        logic set_nak;
        logic clr_nak;
        logic set_stall;
        logic clr_stall;
        logic set_data0;
        logic set_even;
        logic set_odd;
    } ep_cmd_t;

    // Decision made for the token seen this cycle.
    typedef struct packed {
        logic respond;
        hs_e  code;
        logic accept;
        logic setup_seen;
        logic flip;
    } ep_resp_t;

endpackage

// File: rtl/usb_out_ep_resp.sv
// Combinational response selector.
// Decides handshake, acceptance and engine-side events for one token using
// the flag state before the current edge. Assumes at most one token per cycle.
module usb_out_ep_resp
    import usb_out_ep_pkg::*;
(
    input  ep_kind_e kind,
    input  logic     snoop,
    input  logic     tok_valid,
    input  logic     tok_setup,
    input  logic     tok_data1,
    input  logic     tok_bad,
    input  logic     tok_frame_odd,
    input  logic     ep_en,
    input  logic     ep_dis,
    input  logic     ep_nak,
    input  logic     ep_stall,
    input  logic     ep_data1,
    input  logic     ep_odd,
    input  logic     glb_in_nak,
    input  logic     glb_out_nak,
    output ep_resp_t resp
);

    logic pkt_good;
    logic hold_off;

    assign pkt_good = !tok_bad || snoop;
    assign hold_off = ep_nak || glb_in_nak || glb_out_nak || !ep_en || ep_dis;

    // Select handshake and side effects for the current token.
    always_comb begin
        resp = '0;
        if (tok_valid) begin
            if (tok_setup) begin
                if (kind == EP_CTRL) begin
                    resp.respond    = 1'b1;
                    resp.code       = HS_ACK;
                    resp.accept     = 1'b1;
                    resp.setup_seen = 1'b1;
                end
            end else if (kind == EP_ISO) begin
                resp.accept = pkt_good && !hold_off && (tok_frame_odd == ep_odd);
            end else if (pkt_good) begin
                resp.respond = 1'b1;
                if (ep_stall) begin
                    resp.code = HS_STALL;
                end else if (hold_off) begin
                    resp.code = HS_NAK;
                end else begin
                    resp.code   = HS_ACK;
                    resp.accept = (tok_data1 == ep_data1);
                    resp.flip   = (tok_data1 == ep_data1);
                end
            end
        end
    end

endmodule

// File: rtl/usb_out_ep_flags.sv
// Flag register set: NAK, STALL, data toggle and frame parity.
// Applies application commands and engine events with set-wins rules.
// Assumes commands are one-cycle pulses and the type is static.
module usb_out_ep_flags
    import usb_out_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ep_kind_e kind,
    input  ep_cmd_t  cmd,
    input  logic     xfer_done,
    input  logic     setup_seen,
    input  logic     flip,
    output logic     nak_q,
    output logic     stall_q,
    output logic     data1_q,
    output logic     odd_q
);

    logic is_iso;
    logic is_bulk_intr;

    assign is_iso       = (kind == EP_ISO);
    assign is_bulk_intr = (kind == EP_BULK) || (kind == EP_INTR);

    // NAK: any setter wins over the application clear.
    always_ff @(posedge clk) begin
        if (!rst_n) nak_q <= 1'b0;
        else        nak_q <= cmd.set_nak || setup_seen || xfer_done || (nak_q && !cmd.clr_nak);
    end

    // STALL: type-dependent set and clear rights; SETUP clears on control.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= (cmd.set_stall && !is_iso)
                             || (stall_q && !(cmd.clr_stall && is_bulk_intr) && !setup_seen);
    end

    // Data toggle: SETUP forces DATA1, set-DATA0 beats a flip.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data1_q <= 1'b0;
        else if (setup_seen)                    data1_q <= 1'b1;
        else if (cmd.set_data0 && is_bulk_intr) data1_q <= 1'b0;
        else if (flip)                          data1_q <= !data1_q;
    end

    // Frame parity: isochronous only, odd wins over even.
    always_ff @(posedge clk) begin
        if (!rst_n)                      odd_q <= 1'b0;
        else if (is_iso && cmd.set_odd)  odd_q <= 1'b1;
        else if (is_iso && cmd.set_even) odd_q <= 1'b0;
    end

endmodule

// File: rtl/usb_out_ep_life.sv
// Enable and disable sequencing with the endpoint-disabled interrupt.
// A disable accepted while enabled raises a one-cycle pending flag, then
// drops enable and pending together, then pulses the interrupt.
module usb_out_ep_life (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_enable,
    input  logic cmd_disable,
    output logic en_q,
    output logic dis_q,
    output logic irq_q
);

    logic stopped_q;

    // Pending flag: only accepted while enabled and not already stopping.
    always_ff @(posedge clk) begin
        if (!rst_n) dis_q <= 1'b0;
        else        dis_q <= cmd_disable && en_q && !dis_q;
    end

    // Enable: cleared as the pending flag drops, enable ignored meanwhile.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (dis_q) en_q <= 1'b0;
        else            en_q <= en_q || cmd_enable;
    end

    // Interrupt: one cycle after the endpoint has stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            stopped_q <= dis_q;
            irq_q     <= stopped_q;
        end
    end

endmodule

// File: rtl/usb_out_ep_ctrl.sv
// Top of the OUT endpoint controller.
// Wires the response selector, flag registers and disable sequencer, and
// registers the handshake so it appears one cycle after the token.
module usb_out_ep_ctrl
    import usb_out_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_ep_type,
    input  logic       cfg_snoop,
    input  logic       cmd_enable,
    input  logic       cmd_disable,
    input  logic       cmd_set_nak,
    input  logic       cmd_clr_nak,
    input  logic       cmd_set_stall,
    input  logic       cmd_clr_stall,
    input  logic       cmd_set_data0,
    input  logic       cmd_set_even,
    input  logic       cmd_set_odd,
    input  logic       glb_in_nak,
    input  logic       glb_out_nak,
    input  logic       tok_valid,
    input  logic       tok_setup,
    input  logic       tok_data1,
    input  logic       tok_bad,
    input  logic       tok_frame_odd,
    input  logic       xfer_done,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       rx_accept,
    output logic       ep_enabled,
    output logic       ep_dis_pend,
    output logic       ep_nak,
    output logic       ep_stall,
    output logic       ep_data1,
    output logic       ep_frame_odd,
    output logic       irq_ep_disabled
);

    ep_kind_e kind;
    ep_cmd_t  cmd;
    ep_resp_t resp;

    assign kind = ep_kind_e'(cfg_ep_type);
    assign cmd  = '{set_nak:   cmd_set_nak,   clr_nak:   cmd_clr_nak,
                    set_stall: cmd_set_stall, clr_stall: cmd_clr_stall,
                    set_data0: cmd_set_data0, set_even:  cmd_set_even,
                    set_odd:   cmd_set_odd};

    usb_out_ep_resp i_resp (
        .kind          (kind),
        .snoop         (cfg_snoop),
        .tok_valid     (tok_valid),
        .tok_setup     (tok_setup),
        .tok_data1     (tok_data1),
        .tok_bad       (tok_bad),
        .tok_frame_odd (tok_frame_odd),
        .ep_en         (ep_enabled),
        .ep_dis        (ep_dis_pend),
        .ep_nak        (ep_nak),
        .ep_stall      (ep_stall),
        .ep_data1      (ep_data1),
        .ep_odd        (ep_frame_odd),
        .glb_in_nak    (glb_in_nak),
        .glb_out_nak   (glb_out_nak),
        .resp          (resp)
    );

    usb_out_ep_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .cmd        (cmd),
        .xfer_done  (xfer_done),
        .setup_seen (resp.setup_seen),
        .flip       (resp.flip),
        .nak_q      (ep_nak),
        .stall_q    (ep_stall),
        .data1_q    (ep_data1),
        .odd_q      (ep_frame_odd)
    );

    usb_out_ep_life i_life (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .en_q        (ep_enabled),
        .dis_q       (ep_dis_pend),
        .irq_q       (irq_ep_disabled)
    );

    // Handshake output register: one cycle after the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid  <= 1'b0;
            hs_code   <= HS_ACK;
            rx_accept <= 1'b0;
        end else begin
            hs_valid  <= resp.respond;
            hs_code   <= resp.code;
            rx_accept <= resp.accept;
        end
    end

endmodule

// File: rtl/usb_out_ep_chk.sv
// Property checker for the OUT endpoint controller, bound to the top.
// Assumes only the top-level ports; no internal signals are observed.
module usb_out_ep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_ep_type,
    input logic       cfg_snoop,
    input logic       cmd_set_nak,
    input logic       cmd_set_stall,
    input logic       tok_valid,
    input logic       tok_setup,
    input logic       tok_bad,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       ep_enabled,
    input logic       ep_dis_pend,
    input logic       ep_nak,
    input logic       ep_stall,
    input logic       irq_ep_disabled
);

    AST_HS_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(tok_valid)); // R2

    AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_setup && cfg_ep_type != 2'b01 && ep_stall && (!tok_bad || cfg_snoop)
        |=> hs_valid && hs_code == 2'b10); // R2

    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_setup && cfg_ep_type == 2'b00 && !cmd_set_stall
        |=> hs_valid && hs_code == 2'b00 && ep_nak && !ep_stall); // R3

    AST_CTRL_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ep_type == 2'b00 && ep_stall && !(tok_valid && tok_setup) |=> ep_stall); // R4

    AST_NAK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set_nak |=> ep_nak); // R5

    AST_ISO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_setup && cfg_ep_type == 2'b01 |=> !hs_valid); // R7

    AST_DIS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ep_dis_pend |=> !ep_dis_pend); // R9

    AST_DIS_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ep_dis_pend) |-> !ep_enabled); // R9

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ep_dis_pend) |=> irq_ep_disabled); // R9

    AST_DIS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enabled |=> !ep_dis_pend); // R10

    AST_NAK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_setup && cfg_ep_type != 2'b01 && !ep_stall
        && (!ep_enabled || ep_dis_pend) && (!tok_bad || cfg_snoop)
        |=> hs_valid && hs_code == 2'b01); // R11

endmodule

bind usb_out_ep_ctrl usb_out_ep_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_ep_type     (cfg_ep_type),
    .cfg_snoop       (cfg_snoop),
    .cmd_set_nak     (cmd_set_nak),
    .cmd_set_stall   (cmd_set_stall),
    .tok_valid       (tok_valid),
    .tok_setup       (tok_setup),
    .tok_bad         (tok_bad),
    .hs_valid        (hs_valid),
    .hs_code         (hs_code),
    .ep_enabled      (ep_enabled),
    .ep_dis_pend     (ep_dis_pend),
    .ep_nak          (ep_nak),
    .ep_stall        (ep_stall),
    .irq_ep_disabled (irq_ep_disabled)
);

// File: tb/test_usb_out_ep_ctrl.sv
// Bench: random plus directed stimulus against a cycle model built from the requirements.
module test_usb_out_ep_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_ep_type = 2'b10;
    logic cfg_snoop = 1'b0;
    logic cmd_enable, cmd_disable, cmd_set_nak, cmd_clr_nak, cmd_set_stall, cmd_clr_stall;
    logic cmd_set_data0, cmd_set_even, cmd_set_odd, glb_in_nak, glb_out_nak;
    logic tok_valid, tok_setup, tok_data1, tok_bad, tok_frame_odd, xfer_done;
    logic hs_valid, rx_accept, ep_enabled, ep_dis_pend, ep_nak, ep_stall;
    logic ep_data1, ep_frame_odd, irq_ep_disabled;
    logic [1:0] hs_code;

    int total = 0;
    int bad = 0;

    // Model state
    bit m_en, m_dis, m_stop, m_irq, m_nak, m_stall, m_d1, m_odd, m_hsv, m_acc;
    bit [1:0] m_code;

    always #4 clk = ~clk;

    usb_out_ep_ctrl i_usb_out_ep_ctrl (.*);

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        {cmd_enable, cmd_disable, cmd_set_nak, cmd_clr_nak, cmd_set_stall, cmd_clr_stall} = '0;
        {cmd_set_data0, cmd_set_even, cmd_set_odd, glb_in_nak, glb_out_nak} = '0;
        {tok_valid, tok_setup, tok_data1, tok_bad, tok_frame_odd, xfer_done} = '0;
    endtask

    // Next-state model derived from R2..R11.
    task automatic model_step();
        bit good, hold, setup, flip, hsv, acc, ctl, iso, bi;
        bit [1:0] code;
        ctl = cfg_ep_type == 2'b00; iso = cfg_ep_type == 2'b01; bi = cfg_ep_type[1];
        good = !tok_bad || cfg_snoop;
        hold = m_nak || glb_in_nak || glb_out_nak || !m_en || m_dis;
        {setup, flip, hsv, acc} = '0; code = 2'b00;
        if (tok_valid) begin
            if (tok_setup) begin
                if (ctl) begin hsv = 1; acc = 1; setup = 1; end
            end else if (iso) begin
                acc = good && !hold && (tok_frame_odd == m_odd);
            end else if (good) begin
                hsv = 1;
                if (m_stall) code = 2'b10;
                else if (hold) code = 2'b01;
                else begin acc = (tok_data1 == m_d1); flip = acc; end
            end
        end
        m_hsv = hsv; m_code = code; m_acc = acc;
        m_nak = cmd_set_nak || setup || xfer_done || (m_nak && !cmd_clr_nak);
        m_stall = (cmd_set_stall && !iso) || (m_stall && !(cmd_clr_stall && bi) && !setup);
        if (setup) m_d1 = 1;
        else if (cmd_set_data0 && bi) m_d1 = 0;
        else if (flip) m_d1 = !m_d1;
        if (iso && cmd_set_odd) m_odd = 1;
        else if (iso && cmd_set_even) m_odd = 0;
        m_irq = m_stop;
        m_stop = m_dis;
        m_en = m_dis ? 1'b0 : (m_en || cmd_enable);
        m_dis = cmd_disable && (m_en || m_stop) && !m_stop ? 1'b0 : m_dis;
    endtask

    // Compare every output with the model.
    task automatic compare_all();
        chk("R2 hs_valid", hs_valid, m_hsv);
        if (m_hsv) chk("R2 hs_code", hs_code, m_code);
        chk("R6 rx_accept", rx_accept, m_acc);
        chk("R9 ep_enabled", ep_enabled, m_en);
        chk("R9 ep_dis_pend", ep_dis_pend, m_dis);
        chk("R9 irq", irq_ep_disabled, m_irq);
        chk("R5 ep_nak", ep_nak, m_nak);
        chk("R4 ep_stall", ep_stall, m_stall);
        chk("R6 ep_data1", ep_data1, m_d1);
        chk("R7 ep_frame_odd", ep_frame_odd, m_odd);
    endtask

    // One clock: model from current inputs, then sample after the edge.
    task automatic step();
        bit was_en, was_dis;
        was_en = m_en; was_dis = m_dis;
        model_step();
        m_dis = cmd_disable && was_en && !was_dis;
        @(posedge clk);
        #1;
        compare_all();
        idle_in();
    endtask

    task automatic out_tok(bit d1, bit badp, bit fodd);
        tok_valid = 1; tok_setup = 0; tok_data1 = d1; tok_bad = badp; tok_frame_odd = fodd;
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1b2c_3d4e));
        idle_in();
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 outputs", {hs_valid, hs_code, rx_accept, ep_enabled, ep_dis_pend, ep_nak,
                           ep_stall, ep_data1, ep_frame_odd, irq_ep_disabled}, 0);
        rst_n = 1'b1;

        // R11: bulk OUT on disabled endpoint -> NAK
        cfg_ep_type = 2'b10;
        out_tok(0, 0, 0); step();
        chk("R11 nak when disabled", {hs_valid, hs_code}, 3'b101);
        // R10: disable while off ignored
        cmd_disable = 1; step();
        chk("R10 no pending", ep_dis_pend, 0);
        step(); step(); chk("R10 no irq", irq_ep_disabled, 0);

        // R6: enable, DATA0 accepted and toggle flips; repeat rejected
        cmd_enable = 1; step();
        out_tok(0, 0, 0); step();
        chk("R6 accept", {hs_valid, hs_code, rx_accept, ep_data1}, 5'b10011);
        out_tok(0, 0, 0); step();
        chk("R6 resend ack no accept", {hs_valid, hs_code, rx_accept, ep_data1}, 5'b10001);
        cmd_set_data0 = 1; step();
        chk("R6 set data0", ep_data1, 0);

        // R8: bad packet dropped without snoop, accepted with snoop
        out_tok(0, 1, 0); step();
        chk("R8 bad silent", {hs_valid, rx_accept}, 0);
        cfg_snoop = 1; out_tok(0, 1, 0); step();
        chk("R8 snoop accepts", {hs_valid, rx_accept}, 2'b11);
        cfg_snoop = 0;

        // R2: STALL beats all NAK sources
        cmd_set_stall = 1; cmd_set_nak = 1; step();
        glb_in_nak = 1; glb_out_nak = 1; out_tok(1, 0, 0); step();
        chk("R2 stall priority", {hs_valid, hs_code}, 3'b110);
        cmd_clr_stall = 1; cmd_clr_nak = 1; step();
        chk("R4 bulk clear", {ep_stall, ep_nak}, 0);

        // R5: transfer complete vs clear-NAK
        xfer_done = 1; cmd_clr_nak = 1; step();
        chk("R5 engine set wins", ep_nak, 1);

        // R9: disable sequence, enable ignored while pending
        cmd_disable = 1; step();
        chk("R9 pending", {ep_enabled, ep_dis_pend}, 2'b11);
        cmd_enable = 1; step();
        chk("R9 stopped", {ep_enabled, ep_dis_pend, irq_ep_disabled}, 0);
        step();
        chk("R9 irq", irq_ep_disabled, 1);
        step();
        chk("R9 irq one cycle", irq_ep_disabled, 0);

        // R3/R4: control endpoint
        cfg_ep_type = 2'b00;
        cmd_set_stall = 1; step();
        cmd_clr_stall = 1; step();
        chk("R4 ctrl clear ignored", ep_stall, 1);
        tok_valid = 1; tok_setup = 1; step();
        chk("R3 setup", {hs_valid, hs_code, rx_accept, ep_nak, ep_stall, ep_data1}, 7'b1001101);
        cfg_ep_type = 2'b10; tok_valid = 1; tok_setup = 1; cmd_clr_nak = 1; step();
        chk("R3 setup non-ctrl", {hs_valid, ep_data1}, 2'b01);

        // R7: isochronous parity
        cfg_ep_type = 2'b01; cmd_enable = 1; cmd_set_odd = 1; cmd_set_stall = 1; step();
        chk("R7 odd set", {ep_frame_odd, ep_stall}, 2'b10);
        out_tok(0, 0, 1); step();
        chk("R7 odd accepted", {hs_valid, rx_accept}, 2'b01);
        out_tok(0, 0, 0); step();
        chk("R7 even dropped", {hs_valid, rx_accept}, 0);

        // Random phases across all types
        for (int ph = 0; ph < 16; ph++) begin
            cfg_ep_type = 2'(ph % 4);
            cfg_snoop = $urandom_range(0, 3) == 0;
            for (int c = 0; c < 1000; c++) begin
                cmd_enable    = $urandom_range(0, 7) == 0;
                cmd_disable   = $urandom_range(0, 15) == 0;
                cmd_set_nak   = $urandom_range(0, 15) == 0;
                cmd_clr_nak   = $urandom_range(0, 5) == 0;
                cmd_set_stall = $urandom_range(0, 31) == 0;
                cmd_clr_stall = $urandom_range(0, 7) == 0;
                cmd_set_data0 = $urandom_range(0, 15) == 0;
                cmd_set_even  = $urandom_range(0, 15) == 0;
                cmd_set_odd   = $urandom_range(0, 15) == 0;
                glb_in_nak    = $urandom_range(0, 15) == 0;
                glb_out_nak   = $urandom_range(0, 15) == 0;
                xfer_done     = $urandom_range(0, 31) == 0;
                tok_valid     = $urandom_range(0, 2) == 0;
                tok_setup     = $urandom_range(0, 5) == 0;
                tok_data1     = 1'($urandom);
                tok_bad       = $urandom_range(0, 7) == 0;
                tok_frame_odd = 1'($urandom);
                step();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule